// File: doc/BRIEF.md
# Sector Erase Command Timer

This block is the command front end of a parallel NOR flash for the sector-erase operation. It watches the chip-enable, write-enable and output-enable strobes. It filters out strobes that are too short and turns each clean low pulse into one write. It decodes the six-write unlock-and-erase sequence and records the addressed sector in a bitmap. It then opens an acceptance window. While the window is open, one-write commands may add more sectors, and each one added restarts the window. When the window runs out, the block enters an internal erase busy phase of fixed length. When that phase ends, the block publishes the set of erased sectors and returns to read mode.

A status byte is always driven on `dout`, and it is meaningful on every read strobe (chip enable and output enable both low):

- Bit 7 is the data-polling flag.
- Bit 6 is the toggle flag.
- Bit 3 is the window flag.
- All other bits are 0.

The control path is one state machine with these states: READ, UNL1, UNL2, SETUP, UNL4, UNL5, WINDOW and BUSY.

- READ moves to UNL1 on 0xAA written to 0x555.
- UNL1 moves to UNL2 on 0x55 written to 0x2AA.
- UNL2 moves to SETUP on 0x80 written to 0x555.
- SETUP moves to UNL4 on 0xAA written to 0x555.
- UNL4 moves to UNL5 on 0x55 written to 0x2AA.
- UNL5 moves to WINDOW on 0x30 written to any sector address.
- Any other write in UNL1 through UNL5 returns the machine to READ.
- WINDOW stays in WINDOW on each extra 0x30 write (sector added, timer restarted).
- WINDOW moves to BUSY when the window timer expires.
- BUSY moves to READ when the busy timer expires.

Top module: `sector_erase_timer`

## Requirements
- R1: After reset the block is in read mode. `dout` reads 0x80 (bit 7 = 1, bit 6 = 0, bit 3 = 0) and `erased_map` is 0.
- R2: A write is taken only when `ce_n`=0, `we_n`=0 and `oe_n`=1 hold together for MIN_W consecutive clock samples. A strobe with `oe_n` low is not a write.
- R3: A write strobe held for fewer than MIN_W samples has no effect, either during the unlock sequence or in the window.
- R4: The sequence 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x30@sector opens the window. The compare uses address bits [10:0]. The sector index is address bits [14:11]. Wrong data at any step returns to read mode with no window.
- R5: While the window is open, bit 7 and bit 3 read 0. Each 0x30 write adds `addr[14:11]` to the set and restarts the WIN_CYC timer. Writes with any other data leave the set unchanged.
- R6: When WIN_CYC cycles pass with no added sector, bit 3 reads 1 and bit 7 reads 0 for BUSY_CYC cycles. All writes in this phase are ignored.
- R7: During the window and during busy, bit 6 inverts on every read strobe. In read mode it holds its value.
- R8: When busy ends, `dout` reads bit 7 = 1 and bit 3 = 0, and `erased_map` equals exactly the set of accepted sectors of that operation (bit n = sector n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 15 | Address; [10:0] command compare, [14:11] sector |
| din | input | 8 | Write data |
| dout | output | 8 | Status byte: bit 7 polling, bit 6 toggle, bit 3 window |
| erased_map | output | 16 | Sectors erased by the last completed operation |

## Verification
The assertions assume that the strobe and address inputs are synchronous to the clock and stable around each rising edge. The bench meets this by changing every input on the falling edge. The assertions also assume that a write and a read strobe never overlap. The bench therefore drives `oe_n` high for every write except the deliberate inhibit case, and returns all strobes high for at least one cycle between operations. Timed checks are placed with margins of tens of cycles on either side of the window and busy limits. This way no sample falls on the cycle where the window or busy timer expires.

// File: rtl/se_pkg.sv
package se_pkg;
    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] ADR_A = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_B = 11'h2AA;

    localparam logic [7:0] CMD_UNL_A = 8'hAA;
    localparam logic [7:0] CMD_UNL_B = 8'h55;
    localparam logic [7:0] CMD_SETUP = 8'h80;
    localparam logic [7:0] CMD_SECT  = 8'h30;

    typedef enum logic [2:0] {
        ST_READ,
        ST_UNL1,
        ST_UNL2,
        ST_SETUP,
        ST_UNL4,
        ST_UNL5,
        ST_WINDOW,
        ST_BUSY
    } se_state_t;
endpackage

// File: rtl/se_strobe_filter.sv
module se_strobe_filter #(
    parameter int MIN_W = 3,
    parameter int AW    = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_pls,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          qual;
    logic [CW-1:0] cnt;
    logic          hit;

    assign qual = ~ce_n & ~we_n & oe_n;
    assign hit  = qual && (cnt == CW'(MIN_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            wr_pls  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            if (!qual)
                cnt <= '0;
            else if (cnt != CW'(MIN_W))
                cnt <= cnt + 1'b1;
            wr_pls <= hit;
            if (hit) begin
                wr_addr <= addr;
                wr_data <= din;
            end
        end
    end

    assert_pulse_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pls |-> $past(qual));

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pls |=> !wr_pls);
endmodule

// File: rtl/se_cycle_timer.sv
module se_cycle_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            run  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                run <= 1'b1;
                cnt <= '0;
            end else if (run) begin
                if (cnt == CW'(LEN - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_done_after_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(run));
endmodule

// File: rtl/se_sector_set.sv
module se_sector_set #(
    parameter int NSECT = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     add,
    input  logic [$clog2(NSECT)-1:0] idx,
    input  logic                     commit,
    output logic [NSECT-1:0]         set_q,
    output logic [NSECT-1:0]         erased_map
);
    localparam int IW = $clog2(NSECT);

    for (genvar i = 0; i < NSECT; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                set_q[i]      <= 1'b0;
                erased_map[i] <= 1'b0;
            end else if (commit) begin
                erased_map[i] <= set_q[i];
                set_q[i]      <= 1'b0;
            end else if (add && (idx == IW'(i))) begin
                set_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sector_erase_timer.sv
module sector_erase_timer
    import se_pkg::*;
#(
    parameter int SECT_BITS = 4,
    parameter int MIN_W     = 3,
    parameter int WIN_CYC   = 50,
    parameter int BUSY_CYC  = 80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ce_n,
    input  logic                        we_n,
    input  logic                        oe_n,
    input  logic [CMD_AW+SECT_BITS-1:0] addr,
    input  logic [7:0]                  din,
    output logic [7:0]                  dout,
    output logic [(1<<SECT_BITS)-1:0]   erased_map
);
    localparam int AW    = CMD_AW + SECT_BITS;
    localparam int NSECT = 1 << SECT_BITS;

    se_state_t          state, state_n;
    logic               wr_pls;
    logic [AW-1:0]      wr_addr;
    logic [7:0]         wr_data;
    logic [CMD_AW-1:0]  lo;
    logic [SECT_BITS-1:0] sect;
    logic               add_sect, win_start, busy_start, commit;
    logic               win_done, busy_done;
    logic [NSECT-1:0]   sect_set;
    logic               rd_now, rd_d, rd_start, active, q6;

    se_strobe_filter #(.MIN_W(MIN_W), .AW(AW)) u_filt (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din),
        .wr_pls(wr_pls), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    se_cycle_timer #(.LEN(WIN_CYC)) u_win (
        .clk(clk), .rst_n(rst_n), .start(win_start), .done(win_done)
    );

    se_cycle_timer #(.LEN(BUSY_CYC)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(busy_start), .done(busy_done)
    );

    se_sector_set #(.NSECT(NSECT)) u_set (
        .clk(clk), .rst_n(rst_n), .add(add_sect), .idx(sect),
        .commit(commit), .set_q(sect_set), .erased_map(erased_map)
    );

    assign lo   = wr_addr[CMD_AW-1:0];
    assign sect = wr_addr[AW-1:CMD_AW];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_READ;
        else
            state <= state_n;
    end

    // next state and sequencing strobes
    always_comb begin
        state_n    = state;
        add_sect   = 1'b0;
        win_start  = 1'b0;
        busy_start = 1'b0;
        commit     = 1'b0;
        unique case (state)
            ST_READ:
                if (wr_pls)
                    state_n = (wr_data == CMD_UNL_A && lo == ADR_A) ? ST_UNL1 : ST_READ;
            ST_UNL1:
                if (wr_pls)
                    state_n = (wr_data == CMD_UNL_B && lo == ADR_B) ? ST_UNL2 : ST_READ;
            ST_UNL2:
                if (wr_pls)
                    state_n = (wr_data == CMD_SETUP && lo == ADR_A) ? ST_SETUP : ST_READ;
            ST_SETUP:
                if (wr_pls)
                    state_n = (wr_data == CMD_UNL_A && lo == ADR_A) ? ST_UNL4 : ST_READ;
            ST_UNL4:
                if (wr_pls)
                    state_n = (wr_data == CMD_UNL_B && lo == ADR_B) ? ST_UNL5 : ST_READ;
            ST_UNL5:
                if (wr_pls) begin
                    if (wr_data == CMD_SECT) begin
                        state_n   = ST_WINDOW;
                        add_sect  = 1'b1;
                        win_start = 1'b1;
                    end else begin
                        state_n = ST_READ;
                    end
                end
            ST_WINDOW:
                if (win_done) begin
                    state_n    = ST_BUSY;
                    busy_start = 1'b1;
                end else if (wr_pls && wr_data == CMD_SECT) begin
                    add_sect  = 1'b1;
                    win_start = 1'b1;
                end
            ST_BUSY:
                if (busy_done) begin
                    state_n = ST_READ;
                    commit  = 1'b1;
                end
            default:
                state_n = ST_READ;
        endcase
    end

    // status outputs
    assign rd_now = ~ce_n & ~oe_n & we_n;
    assign rd_start = rd_now & ~rd_d;
    assign active = (state == ST_WINDOW) || (state == ST_BUSY);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_d <= 1'b0;
            q6   <= 1'b0;
        end else begin
            rd_d <= rd_now;
            if (rd_start && active)
                q6 <= ~q6;
        end
    end

    assign dout = {~active, q6, 2'b00, (state == ST_BUSY), 3'b000};

    assert_q3_rise_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout[3]) |-> $past(win_done));

    assert_busy_freezes_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && !busy_done) |=> $stable(sect_set));

    assert_map_only_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(erased_map) |-> $past(state) == ST_BUSY);

    assert_q6_still_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_READ && state == ST_READ) |-> $stable(dout[6]));
endmodule

// File: tb/sim_sector_erase_timer.sv
module sim_sector_erase_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic [15:0] erased_map;

    int total = 0;
    int bad = 0;
    bit tq6 = 1'b0;
    bit finished = 1'b0;

    typedef struct {
        bit          is_map;
        logic [15:0] v;
        string       tag;
    } item_t;
    item_t sbq[$];
    event smp_ev;

    always #2 clk = ~clk;

    sector_erase_timer u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .erased_map(erased_map)
    );

    // monitor: pop expected item and compare with the port
    always @(smp_ev) begin
        item_t it;
        logic [15:0] act;
        total++;
        if (sbq.size() == 0) begin
            bad++;
            $display("FAIL scoreboard empty act=%h exp=none", dout);
        end else begin
            it = sbq.pop_front();
            act = it.is_map ? erased_map : {8'h00, dout};
            if (act !== it.v) begin
                bad++;
                $display("FAIL %s act=%h exp=%h", it.tag, act, it.v);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d,
                      input int len = 4, input bit oe_lo = 1'b0);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lo ? 1'b0 : 1'b1;
        repeat (len) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic prefix;
        wr(15'h0555, 8'hAA);
        wr(15'h02AA, 8'h55);
        wr(15'h0555, 8'h80);
        wr(15'h0555, 8'hAA);
        wr(15'h02AA, 8'h55);
    endtask

    function automatic logic [14:0] sa(input logic [3:0] s, input logic [10:0] low = 11'h000);
        return {s, low};
    endfunction

    task automatic rd(input bit q7, input bit q3, input bit act, input string tag);
        item_t it;
        if (act) tq6 = ~tq6;
        it.is_map = 1'b0;
        it.v = {8'h00, q7, tq6, 2'b00, q3, 3'b000};
        it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        @(negedge clk);
        #1 -> smp_ev;
        #0;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic chk_map(input logic [15:0] e, input string tag);
        item_t it;
        it.is_map = 1'b1; it.v = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        #1 -> smp_ev;
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        summary();
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);

        // R1 reset state
        rd(1'b1, 1'b0, 1'b0, "R1 reset status");
        chk_map(16'h0000, "R1 reset map");

        // R3 short final strobe does not open the window
        prefix();
        wr(sa(4'd2), 8'h30, 2);
        idle(3);
        rd(1'b1, 1'b0, 1'b0, "R3 glitch strobe ignored");
        wr(15'h0000, 8'hF0);

        // R2 oe_n low inhibits the final write
        prefix();
        wr(sa(4'd2), 8'h30, 4, 1'b1);
        idle(3);
        rd(1'b1, 1'b0, 1'b0, "R2 oe low inhibits write");
        wr(15'h0000, 8'hF0);

        // R4 wrong data mid-sequence aborts
        wr(15'h0555, 8'hAA);
        wr(15'h02AA, 8'h55);
        wr(15'h0555, 8'h77);
        wr(15'h0555, 8'hAA);
        wr(15'h02AA, 8'h55);
        wr(sa(4'd2), 8'h30);
        idle(3);
        rd(1'b1, 1'b0, 1'b0, "R4 abort on bad data");

        // single sector 5
        prefix();
        wr(sa(4'd5), 8'h30);
        idle(5);
        rd(1'b0, 1'b0, 1'b1, "R5 window flags");
        rd(1'b0, 1'b0, 1'b1, "R7 toggle in window");
        wr(sa(4'd9), 8'h50);
        idle(50);
        rd(1'b0, 1'b1, 1'b1, "R6 busy flags");
        wr(sa(4'd2), 8'h30);
        rd(1'b0, 1'b1, 1'b1, "R7 toggle in busy");
        idle(100);
        rd(1'b1, 1'b0, 1'b0, "R8 done status");
        chk_map(16'h0020, "R8 single map, R5 other data ignored, R6 busy write ignored");

        // R7 no toggle in read mode
        rd(1'b1, 1'b0, 1'b0, "R7 read mode hold a");
        rd(1'b1, 1'b0, 1'b0, "R7 read mode hold b");

        // multi sector with timer restarts
        prefix();
        wr(sa(4'd1), 8'h30);
        idle(30);
        wr(sa(4'd7), 8'h30);
        idle(30);
        wr(sa(4'd12), 8'h30);
        wr(sa(4'd3), 8'h30, 2);
        idle(25);
        rd(1'b0, 1'b0, 1'b1, "R5 window restarted");
        idle(60);
        rd(1'b0, 1'b1, 1'b1, "R6 busy after restart");
        idle(100);
        rd(1'b1, 1'b0, 1'b0, "R8 multi done");
        chk_map(16'h1082, "R8 multi map, R3 glitch add ignored");

        // top sector with nonzero low bits, oe-low add attempt
        prefix();
        wr(sa(4'd15, 11'h123), 8'h30);
        wr(sa(4'd4), 8'h30, 4, 1'b1);
        idle(70);
        rd(1'b0, 1'b1, 1'b1, "R4 top sector busy");
        idle(100);
        chk_map(16'h8000, "R4 sector field, R2 oe-low add ignored");

        idle(5);
        summary();
    end
endmodule